// File: doc/BRIEF.md
# Segmented Data Memory Decoder with Wait-State Stretching

This block sits between a processor core's data port and the memory system. It maps each 16-bit data address onto exactly one segment: internal dual-port RAM, a reserved hole, a 256-word I/O window, low external RAM or high external RAM. Internal RAM accesses complete at once. An access to an external segment raises that segment's enable and holds the core in a stall for the number of wait-states programmed for that segment.

A separate program-fetch request drives the external ROM enable. It has its own stall counter, which uses the ROM wait field. A single 16-bit configuration register, written by the core, holds the four 4-bit wait counts. It resets to the maximum of 15 in every field, so external devices start out with the slowest timing.

The `REDUCED_RAM` parameter selects the smaller internal RAM of ten 1K-word banks. In that configuration the range from the end of internal RAM up to the I/O window is reserved and flagged as an error.

Top module: `mem_seg_decoder`

## Requirements
- R1: With `REDUCED_RAM=0`, a request to any address in 0x0000–0x3FFF asserts `int_en_o` and no other enable, and `ready_o` is high in the same cycle. With `REDUCED_RAM=1`, the same holds for 0x0000–0x27FF.
- R2: With `REDUCED_RAM=1`, a request to 0x2800–0x3FFF asserts `rsv_err_o` and no enable, `ready_o` is high in the same cycle, and `rdata_o` is zero.
- R3: A request to 0x4000–0x40FF asserts only `io_en_o`.
- R4: A request to 0x4100–0x7FFF asserts only `xlo_en_o`.
- R5: A request to 0x8000–0xFFFF asserts only `xhi_en_o`.
- R6: The wait configuration has the following fields: bits [3:0] for low external RAM, [7:4] for I/O, [11:8] for high external RAM and [15:12] for ROM. After reset every field is 15.
- R7: An access that starts while no access is in progress and whose segment has a wait count of N keeps `ready_o` low for its first N cycles and raises it in cycle N+1. With N=0 the access ends in its first cycle. `ready_o` and all enables are low while `req_i` is low.
- R8: `rom_en_o` follows `fetch_req_i`. `fetch_ready_o` obeys the timing of R7 using the ROM wait field and does not depend on data-side traffic.
- R9: `ext_addr_o` and `ext_wdata_o` pass `addr_i` and `wdata_i` through. `ext_we_o` is `we_i` during an external data access and is otherwise low, and `int_we_o` behaves the same way for internal RAM accesses. `rdata_o` returns `ext_rdata_i` for external segments and `int_rdata_i` for internal RAM.
- R10: If `req_i` drops before `ready_o`, the stall is abandoned. The next request starts a fresh count.
- R11: A configuration write applies to accesses that start after the write cycle. An access already in its stall keeps the count it loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Data access request, held until ready |
| we_i | input | 1 | Data write (1) or read (0) |
| addr_i | input | 16 | Data address |
| wdata_i | input | 16 | Write data from core |
| rdata_o | output | 16 | Read data to core |
| ready_o | output | 1 | Data access completes this cycle |
| fetch_req_i | input | 1 | Program fetch request to external ROM |
| fetch_ready_o | output | 1 | Program fetch completes this cycle |
| cfg_we_i | input | 1 | Wait configuration write strobe |
| cfg_wdata_i | input | 16 | Wait configuration write value |
| int_en_o | output | 1 | Internal RAM enable |
| int_we_o | output | 1 | Internal RAM write |
| int_rdata_i | input | 16 | Internal RAM read data |
| xlo_en_o | output | 1 | Low external RAM enable |
| io_en_o | output | 1 | I/O window enable |
| xhi_en_o | output | 1 | High external RAM enable |
| rom_en_o | output | 1 | External ROM enable |
| ext_we_o | output | 1 | External write |
| ext_addr_o | output | 16 | External address |
| ext_wdata_o | output | 16 | External write data |
| ext_rdata_i | input | 16 | External read data |
| rsv_err_o | output | 1 | Reserved-region access flag |

## Verification
The bench builds two copies of the block that share every input: one with `REDUCED_RAM=1` and one with `REDUCED_RAM=0`. With both copies, the same stimulus to 0x2800–0x3FFF shows the reserved error in the reduced map and plain internal RAM in the full map. Wait counts are checked at 0, small values and the reset value of 15. This covers the single-cycle case as well as a stall that runs to the top of the 4-bit counter.

// File: rtl/mseg_pkg.sv
package mseg_pkg;
  localparam int WAIT_W = 4;
  localparam int CFG_W  = 4 * WAIT_W;

  typedef enum logic [2:0] {
    SEG_INT, SEG_RSV, SEG_XLO, SEG_XIO, SEG_XHI
  } seg_e;

  // field order is fixed by the config register layout (R6)
  typedef struct packed {
    logic [WAIT_W-1:0] rom;
    logic [WAIT_W-1:0] hi;
    logic [WAIT_W-1:0] io;
    logic [WAIT_W-1:0] lo;
  } wait_cfg_t;
endpackage

// File: rtl/mseg_decode.sv
module mseg_decode
  import mseg_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int INT_BANKS  = 16,
  parameter int BANK_WORDS = 1024,
  parameter int IO_BASE    = 'h4000,
  parameter int IO_WORDS   = 256,
  parameter int HI_BASE    = 'h8000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output seg_e              seg_o
);
  localparam int INT_END = INT_BANKS * BANK_WORDS;
  localparam int IO_END  = IO_BASE + IO_WORDS;

  logic [31:0] a;
  assign a = 32'(addr_i);

  always_comb begin
    if (a < 32'(INT_END) && a < 32'(IO_BASE)) seg_o = SEG_INT;
    else if (a < 32'(IO_BASE))                seg_o = SEG_RSV;
    else if (a < 32'(IO_END))                 seg_o = SEG_XIO;
    else if (a < 32'(HI_BASE))                seg_o = SEG_XLO;
    else                                      seg_o = SEG_XHI;
  end
endmodule

// File: rtl/mseg_wait_cfg.sv
module mseg_wait_cfg
  import mseg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output wait_cfg_t        cfg_o
);
  wait_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '1;  // slowest timing at boot
    else if (we_i) cfg_q <= wait_cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i) |-> $stable(cfg_q)) else $error("cfg changed without write"); // R11
endmodule

// File: rtl/mseg_stall_ctr.sv
module mseg_stall_ctr #(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              ready_o
);
  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  logic              busy_q;
  logic [WAIT_W-1:0] cnt_q;

  assign ready_o = req_i && (busy_q ? (cnt_q == ONE) : (wait_i == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!req_i) begin
      busy_q <= 1'b0;  // abandoned access
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (wait_i != '0) begin
        busy_q <= 1'b1;
        cnt_q  <= wait_i;
      end
    end else if (cnt_q == ONE) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  AST_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q != '0) else $error("busy with zero count"); // R7
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> cnt_q == $past(cnt_q) - ONE) else $error("bad step"); // R7
  AST_DROP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !busy_q) else $error("stall survived drop"); // R10
endmodule

// File: rtl/mem_seg_decoder.sv
module mem_seg_decoder
  import mseg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter bit REDUCED_RAM = 1'b0,
  parameter int BANK_WORDS  = 1024,
  parameter int FULL_BANKS  = 16,
  parameter int SMALL_BANKS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  input  logic              fetch_req_i,
  output logic              fetch_ready_o,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic              int_en_o,
  output logic              int_we_o,
  input  logic [DATA_W-1:0] int_rdata_i,
  output logic              xlo_en_o,
  output logic              io_en_o,
  output logic              xhi_en_o,
  output logic              rom_en_o,
  output logic              ext_we_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic              rsv_err_o
);
  localparam int INT_BANKS = REDUCED_RAM ? SMALL_BANKS : FULL_BANKS;

  seg_e              seg;
  wait_cfg_t         cfg;
  logic [WAIT_W-1:0] data_wait;
  logic              is_ext;

  mseg_decode #(
    .ADDR_W(ADDR_W), .INT_BANKS(INT_BANKS), .BANK_WORDS(BANK_WORDS)
  ) u_decode (
    .addr_i(addr_i), .seg_o(seg)
  );

  mseg_wait_cfg u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .wdata_i(cfg_wdata_i), .cfg_o(cfg)
  );

  always_comb begin
    unique case (seg)
      SEG_XLO: data_wait = cfg.lo;
      SEG_XIO: data_wait = cfg.io;
      SEG_XHI: data_wait = cfg.hi;
      default: data_wait = '0;  // internal and reserved never stall
    endcase
  end

  mseg_stall_ctr #(.WAIT_W(WAIT_W)) u_data_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i),
    .wait_i(data_wait), .ready_o(ready_o)
  );

  mseg_stall_ctr #(.WAIT_W(WAIT_W)) u_fetch_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(fetch_req_i),
    .wait_i(cfg.rom), .ready_o(fetch_ready_o)
  );

  assign is_ext    = seg inside {SEG_XLO, SEG_XIO, SEG_XHI};
  assign int_en_o  = req_i && (seg == SEG_INT);
  assign int_we_o  = int_en_o && we_i;
  assign xlo_en_o  = req_i && (seg == SEG_XLO);
  assign io_en_o   = req_i && (seg == SEG_XIO);
  assign xhi_en_o  = req_i && (seg == SEG_XHI);
  assign rsv_err_o = req_i && (seg == SEG_RSV);
  assign ext_we_o  = req_i && is_ext && we_i;
  assign rom_en_o  = fetch_req_i;

  assign ext_addr_o  = addr_i;
  assign ext_wdata_o = wdata_i;

  always_comb begin
    if (seg == SEG_INT) rdata_o = int_rdata_i;
    else if (is_ext)    rdata_o = ext_rdata_i;
    else                rdata_o = '0;
  end

  AST_ONE_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({int_en_o, xlo_en_o, io_en_o, xhi_en_o, rsv_err_o})) else $error("enables"); // R3
  AST_INT_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_en_o |-> ready_o) else $error("internal stalled"); // R1
  AST_RSV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_err_o |-> (ready_o && !ext_we_o && !int_we_o)) else $error("reserved"); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !(ready_o || int_en_o || xlo_en_o || io_en_o || xhi_en_o)) else $error("idle"); // R7
  AST_FETCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_req_i |-> !fetch_ready_o) else $error("fetch idle"); // R8
endmodule

// File: tb/mem_seg_decoder_test.sv
module mem_seg_decoder_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, fetch_req = 0, cfg_we = 0;
  logic [15:0] addr = '0, wdata = '0, cfg_wdata = '0;
  logic [15:0] int_rdata = 16'h3C3C, ext_rdata = 16'hA5A5;

  logic [15:0] rdata, ext_addr, ext_wdata, f_rdata, f_ext_addr, f_ext_wdata;
  logic ready, fetch_ready, int_en, int_we, xlo_en, io_en, xhi_en, rom_en, ext_we, rsv_err;
  logic f_ready, f_fetch_ready, f_int_en, f_int_we, f_xlo_en, f_io_en, f_xhi_en;
  logic f_rom_en, f_ext_we, f_rsv_err;

  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  mem_seg_decoder #(.REDUCED_RAM(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .fetch_req_i(fetch_req),
    .fetch_ready_o(fetch_ready), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .int_en_o(int_en), .int_we_o(int_we), .int_rdata_i(int_rdata),
    .xlo_en_o(xlo_en), .io_en_o(io_en), .xhi_en_o(xhi_en), .rom_en_o(rom_en),
    .ext_we_o(ext_we), .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata),
    .ext_rdata_i(ext_rdata), .rsv_err_o(rsv_err));

  mem_seg_decoder #(.REDUCED_RAM(1'b0)) uut_full (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(f_rdata), .ready_o(f_ready), .fetch_req_i(fetch_req),
    .fetch_ready_o(f_fetch_ready), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .int_en_o(f_int_en), .int_we_o(f_int_we), .int_rdata_i(int_rdata),
    .xlo_en_o(f_xlo_en), .io_en_o(f_io_en), .xhi_en_o(f_xhi_en), .rom_en_o(f_rom_en),
    .ext_we_o(f_ext_we), .ext_addr_o(f_ext_addr), .ext_wdata_o(f_ext_wdata),
    .ext_rdata_i(ext_rdata), .rsv_err_o(f_rsv_err));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  // en vector order: {int, xlo, io, xhi, rsv}
  task automatic access(input string tag, input logic [15:0] a, input logic w,
                        input logic [4:0] exp_en, input int exp_w);
    int waits = 0;
    @(negedge clk); addr = a; we = w; wdata = a ^ 16'h5A5A; req = 1;
    #1;
    check({tag, " enables"}, {int_en, xlo_en, io_en, xhi_en, rsv_err}, exp_en);
    while (!ready && waits < 40) begin waits++; @(negedge clk); #1; end
    check({tag, " waits"}, waits, exp_w);
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic t_reset;   // R6 R7
    #1;
    check("R7 idle ready", {ready, int_en, xlo_en, io_en, xhi_en}, 0);
    access("R6 reset hi", 16'h9000, 0, 5'b00010, 15);
    access("R6 reset io", 16'h4000, 0, 5'b00100, 15);
  endtask

  task automatic t_map;     // R1 R3 R4 R5 R6
    write_cfg(16'h4321);
    access("R1 int lo", 16'h0000, 0, 5'b10000, 0);
    access("R1 int top", 16'h27FF, 1, 5'b10000, 0);
    access("R3 io first", 16'h4000, 0, 5'b00100, 2);
    access("R3 io last", 16'h40FF, 0, 5'b00100, 2);
    access("R4 xlo first", 16'h4100, 0, 5'b01000, 1);
    access("R4 xlo last", 16'h7FFF, 1, 5'b01000, 1);
    access("R5 xhi first", 16'h8000, 0, 5'b00010, 3);
    access("R5 xhi last", 16'hFFFF, 0, 5'b00010, 3);
  endtask

  task automatic t_reserved;  // R2 R1
    @(negedge clk); addr = 16'h2800; req = 1; #1;
    check("R2 rsv flag", {rsv_err, int_en, xlo_en, io_en, xhi_en, ready}, 6'b100001);
    check("R2 rsv rdata", rdata, 0);
    check("R1 full map 0x2800", {f_int_en, f_rsv_err, f_ready}, 3'b101);
    @(negedge clk); addr = 16'h3FFF; #1;
    check("R2 rsv top", {rsv_err, ready}, 2'b11);
    check("R1 full map 0x3FFF", {f_int_en, f_rsv_err}, 2'b10);
    @(negedge clk); req = 0;
  endtask

  task automatic t_pass;    // R9
    @(negedge clk); addr = 16'h4123; wdata = 16'hBEEF; we = 1; req = 1; #1;
    check("R9 ext addr", ext_addr, 16'h4123);
    check("R9 ext wdata", ext_wdata, 16'hBEEF);
    check("R9 ext we", {ext_we, int_we}, 2'b10);
    check("R9 ext rdata", rdata, 16'hA5A5);
    @(negedge clk); req = 0; we = 0;
    @(negedge clk); addr = 16'h0100; we = 1; req = 1; #1;
    check("R9 int we", {ext_we, int_we}, 2'b01);
    check("R9 int rdata", rdata, 16'h3C3C);
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic t_fetch;   // R8
    int waits = 0;
    write_cfg(16'h4000);
    @(negedge clk); fetch_req = 1; #1;
    check("R8 rom en", rom_en, 1);
    while (!fetch_ready && waits < 40) begin
      waits++;
      req = 1; addr = 16'h0010; #1;   // data traffic alongside
      check("R8 data runs beside fetch", ready, 1);
      @(negedge clk); req = 0; #1;
    end
    check("R8 fetch waits", waits, 4);
    @(negedge clk); fetch_req = 0; #1;
    check("R8 rom en off", {rom_en, fetch_ready}, 0);
  endtask

  task automatic t_abort;   // R10
    write_cfg(16'h0003);
    @(negedge clk); addr = 16'h5000; req = 1;
    @(negedge clk);
    @(negedge clk); req = 0;
    access("R10 after abort", 16'h5000, 0, 5'b01000, 3);
  endtask

  task automatic t_cfg_mid; // R11
    int waits = 0;
    write_cfg(16'h0300);
    @(negedge clk); addr = 16'hC000; req = 1; #1;
    while (!ready && waits < 40) begin
      waits++;
      cfg_we = (waits == 1); cfg_wdata = 16'h0000;
      @(negedge clk); cfg_we = 0; #1;
    end
    check("R11 in-flight keeps count", waits, 3);
    @(negedge clk); req = 0;
    access("R11 new count", 16'hC000, 0, 5'b00010, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_map();
    t_reserved();
    t_pass();
    t_fetch();
    t_abort();
    t_cfg_mid();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule